// File: doc/BRIEF.md
# I2C Target with Word-Access Mailboxes

This block is an I2C target that carries bytes between the serial bus and two 64-byte storage files. Bytes that the bus controller writes go into a receive file. Bytes for the controller to read come out of a transmit file. A local processor sees both files only as whole 32-bit words. It also sees a small set of control words: the target's own 7-bit address, an interrupt mask, sticky event flags, and two progress pointers. The processor polls the pointers to learn how far the bus side has advanced.

SCL and SDA each pass through a two-stage synchroniser. START and STOP are found from SDA edges while SCL is high. After a START the target shifts in the address byte. It answers with ACK only when the address matches. It then stores written bytes at the receive pointer, or shifts transmit bits MSB first starting at the transmit bit pointer. SDA is driven only through an active-high pull-low enable. The block raises three transaction-phase events: a read has begun, a read has ended, and a write has ended. These are combined through the mask into a single interrupt line.

Top module: `i2c_word_mailbox`

## Requirements
- R1: After reset, sda_oe and irq are 0, both pointers read 0, the event flags read 0 and the own-address register reads 0x42.
- R2: An address byte whose upper seven bits equal the own-address register is acknowledged by pulling SDA low in the ninth clock; any other address leaves SDA released in that clock, and the rest of that transaction stores nothing and sets no flag.
- R3: In a matched write, the data byte received k-th overall is stored at receive byte index (rx pointer), which is bits [8*(b%4)+7 : 8*(b%4)] of receive word b/4; each stored byte is acknowledged and advances the receive pointer by one, modulo 64.
- R4: In a matched read, bits are sent MSB first from transmit byte (tx pointer / 8), bit 7 - (tx pointer % 8); the pointer advances by one per bit shifted out, modulo 512; after the controller answers a byte with NACK, SDA stays released until the next START or STOP.
- R5: Host word addresses 0x00-0x0F map to the receive file (read-only, writes have no effect) and 0x10-0x1F map to the transmit file (read/write). At 0x20 sits the own address [6:0], at 0x21 the event mask [2:0], at 0x22 the event flags [2:0], at 0x23 the receive pointer, and at 0x24 the transmit bit pointer.
- R6: Event flag bit 0 (read begun) is set when a matched address byte with R/W = 1 is acknowledged.
- R7: Event flag bit 1 (read ended) is set by the STOP or repeated START that closes a matched read. Bit 2 (write ended) is set in the same way for a matched write. At most one event occurs per cycle.
- R8: Writing 1 to an event flag bit clears it, and a new event in the same cycle wins. irq is the OR of the flags ANDed with the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock as seen on the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low |
| hst_we | input | 1 | Host write strobe |
| hst_addr | input | 6 | Host word address |
| hst_wdata | input | 32 | Host write word |
| hst_rdata | output | 32 | Host read word, combinational from hst_addr |
| irq | output | 1 | Masked OR of event flags |

## Verification
The checker assumes that the controller changes SDA only while SCL is low, except for the START and STOP conditions. It also assumes that each SCL level lasts well beyond the three-cycle synchroniser delay, so that pointer steps and the ACK drive line up one-for-one. The bench's bus model holds each quarter bit for ten clocks. It also releases SDA before every ACK slot and every target-driven bit. Host accesses are single-cycle writes placed on falling clock edges, and the bench never writes the event flags in the same cycle as a bus event it is checking.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int MBX_BYTES = 64;

    typedef enum logic [2:0] {
        L_IDLE, L_ADDR, L_ADDR_ACK, L_WR_DATA, L_WR_ACK, L_RD_DATA, L_RD_ACK
    } link_st_e;

    typedef enum logic [1:0] {X_NONE, X_WRITE, X_READ} xact_e;

    localparam logic [1:0] REGION_RX  = 2'd0;
    localparam logic [1:0] REGION_TX  = 2'd1;
    localparam logic [1:0] REGION_CSR = 2'd2;

    localparam logic [2:0] CSR_OWN    = 3'd0;
    localparam logic [2:0] CSR_MASK   = 3'd1;
    localparam logic [2:0] CSR_FLAGS  = 3'd2;
    localparam logic [2:0] CSR_RX_PTR = 3'd3;
    localparam logic [2:0] CSR_TX_PTR = 3'd4;

    localparam int EV_RD_START = 0;
    localparam int EV_RD_END   = 1;
    localparam int EV_WR_END   = 2;
endpackage

// File: rtl/mbx_sync.sv
module mbx_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    typedef struct packed {
        logic [1:0] scl_ff;
        logic [1:0] sda_ff;
        logic       scl_p;
        logic       sda_p;
    } sync_t;

    sync_t r_d, r_q;

    always_comb begin
        r_d.scl_ff = {r_q.scl_ff[0], scl_i};
        r_d.sda_ff = {r_q.sda_ff[0], sda_i};
        r_d.scl_p  = r_q.scl_ff[1];
        r_d.sda_p  = r_q.sda_ff[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '1;
        else        r_q <= r_d;
    end

    logic scl_s;
    assign scl_s     = r_q.scl_ff[1];
    assign sda_s     = r_q.sda_ff[1];
    assign scl_rise  = scl_s & ~r_q.scl_p;
    assign scl_fall  = ~scl_s & r_q.scl_p;
    assign start_det = scl_s & r_q.scl_p & r_q.sda_p & ~sda_s;
    assign stop_det  = scl_s & r_q.scl_p & ~r_q.sda_p & sda_s;
endmodule

// File: rtl/mbx_file.sv
module mbx_file #(
    parameter int BYTES = mbx_pkg::MBX_BYTES
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      byte_we,
    input  logic [$clog2(BYTES)-1:0]  byte_idx,
    input  logic [7:0]                byte_wdata,
    input  logic                      word_we,
    input  logic [$clog2(BYTES/4)-1:0] word_idx,
    input  logic [31:0]               word_wdata,
    output logic [BYTES*8-1:0]        contents
);
    localparam int BITS = BYTES * 8;

    logic [BITS-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (word_we) mem_d[{word_idx, 5'b0} +: 32] = word_wdata;
        if (byte_we) mem_d[{byte_idx, 3'b0} +: 8]  = byte_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    assign contents = mem_q;
endmodule

// File: rtl/mbx_link.sv
module mbx_link #(
    parameter int BYTES = mbx_pkg::MBX_BYTES,
    localparam int PTR_W = $clog2(BYTES),
    localparam int TXP_W = PTR_W + 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic [6:0]       own_addr,
    input  logic             tx_bit,
    output logic             sda_oe,
    output logic             rx_we,
    output logic [PTR_W-1:0] rx_idx,
    output logic [7:0]       rx_data,
    output logic [PTR_W-1:0] rx_ptr,
    output logic [TXP_W-1:0] tx_ptr,
    output logic [2:0]       ev
);
    import mbx_pkg::*;

    typedef struct packed {
        link_st_e         st;
        logic [3:0]       bits;
        logic [7:0]       shreg;
        logic             rw;
        logic             nack;
        logic             drive;
        xact_e            xact;
        logic [PTR_W-1:0] rxp;
        logic [TXP_W-1:0] txp;
        logic [2:0]       ev;
        logic             rx_we;
        logic [PTR_W-1:0] rx_idx;
        logic [7:0]       rx_data;
    } link_t;

    link_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.ev    = '0;
        r_d.rx_we = 1'b0;
        if (start_det || stop_det) begin
            if (r_q.xact == X_READ)       r_d.ev[EV_RD_END] = 1'b1;
            else if (r_q.xact == X_WRITE) r_d.ev[EV_WR_END] = 1'b1;
            r_d.xact  = X_NONE;
            r_d.drive = 1'b0;
            r_d.bits  = '0;
            r_d.st    = start_det ? L_ADDR : L_IDLE;
        end else begin
            case (r_q.st)
                L_ADDR, L_WR_DATA: begin
                    if (scl_rise && r_q.bits < 4'd8) begin
                        r_d.shreg = {r_q.shreg[6:0], sda_s};
                        r_d.bits  = r_q.bits + 4'd1;
                    end else if (scl_fall && r_q.bits == 4'd8) begin
                        if (r_q.st == L_ADDR) begin
                            if (r_q.shreg[7:1] == own_addr) begin
                                r_d.drive = 1'b1;
                                r_d.rw    = r_q.shreg[0];
                                r_d.xact  = r_q.shreg[0] ? X_READ : X_WRITE;
                                r_d.ev[EV_RD_START] = r_q.shreg[0];
                                r_d.st    = L_ADDR_ACK;
                            end else begin
                                r_d.st = L_IDLE;
                            end
                        end else begin
                            r_d.rx_we   = 1'b1;
                            r_d.rx_idx  = r_q.rxp;
                            r_d.rx_data = r_q.shreg;
                            r_d.rxp     = r_q.rxp + 1'b1;
                            r_d.drive   = 1'b1;
                            r_d.st      = L_WR_ACK;
                        end
                    end
                end
                L_ADDR_ACK: if (scl_fall) begin
                    r_d.drive = 1'b0;
                    r_d.bits  = '0;
                    r_d.st    = r_q.rw ? L_RD_DATA : L_WR_DATA;
                end
                L_WR_ACK: if (scl_fall) begin
                    r_d.drive = 1'b0;
                    r_d.bits  = '0;
                    r_d.st    = L_WR_DATA;
                end
                L_RD_DATA: if (scl_fall) begin
                    r_d.txp  = r_q.txp + 1'b1;
                    r_d.bits = r_q.bits + 4'd1;
                    if (r_q.bits == 4'd7) r_d.st = L_RD_ACK;
                end
                L_RD_ACK: begin
                    if (scl_rise) r_d.nack = sda_s;
                    if (scl_fall) begin
                        r_d.bits = '0;
                        r_d.st   = r_q.nack ? L_IDLE : L_RD_DATA;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= L_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_oe  = r_q.drive | ((r_q.st == L_RD_DATA) & ~tx_bit);
    assign rx_we   = r_q.rx_we;
    assign rx_idx  = r_q.rx_idx;
    assign rx_data = r_q.rx_data;
    assign rx_ptr  = r_q.rxp;
    assign tx_ptr  = r_q.txp;
    assign ev      = r_q.ev;
endmodule

// File: rtl/i2c_word_mailbox.sv
module i2c_word_mailbox #(
    parameter int         FILE_BYTES = mbx_pkg::MBX_BYTES,
    parameter logic [6:0] DEF_ADDR   = 7'h42,
    localparam int WORDS  = FILE_BYTES / 4,
    localparam int WIDX_W = $clog2(WORDS),
    localparam int PTR_W  = $clog2(FILE_BYTES),
    localparam int TXP_W  = PTR_W + 3,
    localparam int HA_W   = WIDX_W + 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            scl_i,
    input  logic            sda_i,
    output logic            sda_oe,
    input  logic            hst_we,
    input  logic [HA_W-1:0] hst_addr,
    input  logic [31:0]     hst_wdata,
    output logic [31:0]     hst_rdata,
    output logic            irq
);
    import mbx_pkg::*;

    logic sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic tx_bit, rx_we;
    logic [PTR_W-1:0] rx_idx, rx_ptr;
    logic [7:0] rx_data;
    logic [TXP_W-1:0] tx_ptr;
    logic [2:0] ev;
    logic [FILE_BYTES*8-1:0] rx_contents, tx_contents;

    typedef struct packed {
        logic [6:0] own;
        logic [2:0] mask;
        logic [2:0] flags;
    } csr_t;

    csr_t r_d, r_q;

    logic [1:0]        region;
    logic [WIDX_W-1:0] widx;
    logic              csr_hit;
    logic              tx_word_we;
    logic [2:0]        clr;

    assign region     = hst_addr[HA_W-1 -: 2];
    assign widx       = hst_addr[WIDX_W-1:0];
    assign csr_hit    = (region == REGION_CSR) && (hst_addr[WIDX_W-1:3] == '0);
    assign tx_word_we = hst_we && (region == REGION_TX);

    mbx_sync u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    mbx_link #(.BYTES(FILE_BYTES)) u_link (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .own_addr(r_q.own), .tx_bit(tx_bit), .sda_oe(sda_oe),
        .rx_we(rx_we), .rx_idx(rx_idx), .rx_data(rx_data),
        .rx_ptr(rx_ptr), .tx_ptr(tx_ptr), .ev(ev)
    );

    mbx_file #(.BYTES(FILE_BYTES)) u_rx (
        .clk(clk), .rst_n(rst_n), .byte_we(rx_we), .byte_idx(rx_idx),
        .byte_wdata(rx_data), .word_we(1'b0), .word_idx('0),
        .word_wdata('0), .contents(rx_contents)
    );

    mbx_file #(.BYTES(FILE_BYTES)) u_tx (
        .clk(clk), .rst_n(rst_n), .byte_we(1'b0), .byte_idx('0),
        .byte_wdata('0), .word_we(tx_word_we), .word_idx(widx),
        .word_wdata(hst_wdata), .contents(tx_contents)
    );

    assign tx_bit = tx_contents[{tx_ptr[TXP_W-1:3], ~tx_ptr[2:0]}];

    always_comb begin
        r_d = r_q;
        clr = '0;
        if (hst_we && csr_hit) begin
            case (hst_addr[2:0])
                CSR_OWN:   r_d.own  = hst_wdata[6:0];
                CSR_MASK:  r_d.mask = hst_wdata[2:0];
                CSR_FLAGS: clr      = hst_wdata[2:0];
                default: ;
            endcase
        end
        r_d.flags = (r_q.flags & ~clr) | ev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.own   <= DEF_ADDR;
            r_q.mask  <= '0;
            r_q.flags <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        hst_rdata = '0;
        case (region)
            REGION_RX: hst_rdata = rx_contents[{widx, 5'b0} +: 32];
            REGION_TX: hst_rdata = tx_contents[{widx, 5'b0} +: 32];
            REGION_CSR: if (csr_hit) begin
                case (hst_addr[2:0])
                    CSR_OWN:    hst_rdata = 32'(r_q.own);
                    CSR_MASK:   hst_rdata = 32'(r_q.mask);
                    CSR_FLAGS:  hst_rdata = 32'(r_q.flags);
                    CSR_RX_PTR: hst_rdata = 32'(rx_ptr);
                    CSR_TX_PTR: hst_rdata = 32'(tx_ptr);
                    default:    hst_rdata = '0;
                endcase
            end
            default: hst_rdata = '0;
        endcase
    end

    assign irq = |(r_q.flags & r_q.mask);

    logic [2:0] flags_vis;
    assign flags_vis = r_q.flags;
endmodule

module mbx_checker #(
    parameter int PTR_W = 6,
    parameter int TXP_W = 9,
    parameter int HA_W  = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sda_oe,
    input logic             irq,
    input logic [PTR_W-1:0] rx_ptr,
    input logic [TXP_W-1:0] tx_ptr,
    input logic [2:0]       flags,
    input logic [2:0]       ev,
    input logic             hst_we,
    input logic [HA_W-1:0]  hst_addr,
    input logic [2:0]       wbits
);
    import mbx_pkg::*;

    localparam logic [HA_W-1:0] FLAGS_ADDR =
        (HA_W'(REGION_CSR) << (HA_W - 2)) | HA_W'(CSR_FLAGS);

    AST_RX_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ptr != $past(rx_ptr) |-> rx_ptr == PTR_W'($past(rx_ptr) + 1'b1)); // R3
    AST_RX_STORE_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ptr != $past(rx_ptr) |-> sda_oe); // R3
    AST_TX_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ptr != $past(tx_ptr) |-> tx_ptr == TXP_W'($past(tx_ptr) + 1'b1)); // R4
    AST_RD_START_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ev[EV_RD_START] |=> flags[EV_RD_START]); // R6
    AST_RD_END_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ev[EV_RD_END] |=> flags[EV_RD_END]); // R7
    AST_WR_END_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ev[EV_WR_END] |=> flags[EV_WR_END]); // R7
    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ev)); // R7
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_we && hst_addr == FLAGS_ADDR && wbits[0] && !ev[0]) |=> !flags[0]); // R8
    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flags != 3'b000); // R8
endmodule

bind i2c_word_mailbox mbx_checker u_chk (
    .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .irq(irq),
    .rx_ptr(rx_ptr), .tx_ptr(tx_ptr), .flags(flags_vis), .ev(ev),
    .hst_we(hst_we), .hst_addr(hst_addr), .wbits(hst_wdata[2:0])
);

// File: tb/sim_i2c_word_mailbox.sv
`timescale 1ns/1ps
module sim_i2c_word_mailbox;
    localparam int Q = 10;
    localparam logic [5:0] A_OWN = 6'h20, A_MASK = 6'h21, A_FLAGS = 6'h22,
                           A_RXP = 6'h23, A_TXP = 6'h24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_c = 1'b1, sda_c = 1'b1;
    logic sda_oe, irq;
    logic hst_we = 1'b0;
    logic [5:0] hst_addr = '0;
    logic [31:0] hst_wdata = '0;
    logic [31:0] hst_rdata;
    logic sda_bus;
    int n_checks = 0, n_err = 0;
    bit done = 0;

    always #10 clk = ~clk;
    assign sda_bus = sda_c & ~sda_oe;

    i2c_word_mailbox u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_c), .sda_i(sda_bus),
        .sda_oe(sda_oe), .hst_we(hst_we), .hst_addr(hst_addr),
        .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .irq(irq)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic clks(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic h_write(logic [5:0] a, logic [31:0] d);
        @(negedge clk);
        hst_we = 1'b1; hst_addr = a; hst_wdata = d;
        @(negedge clk);
        hst_we = 1'b0;
    endtask

    task automatic h_read(logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        hst_addr = a;
        #1 d = hst_rdata;
    endtask

    task automatic bus_start();
        sda_c = 1'b1; clks(Q); scl_c = 1'b1; clks(Q);
        sda_c = 1'b0; clks(Q); scl_c = 1'b0; clks(Q);
    endtask

    task automatic bus_stop();
        sda_c = 1'b0; clks(Q); scl_c = 1'b1; clks(Q);
        sda_c = 1'b1; clks(Q);
    endtask

    task automatic bus_bit(logic b, output logic seen);
        sda_c = b; clks(Q); scl_c = 1'b1; clks(Q);
        seen = sda_bus; clks(Q); scl_c = 1'b0; clks(Q);
    endtask

    task automatic wr_byte(logic [7:0] v, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bus_bit(v[i], s);
        bus_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic rd_byte(logic give_ack, output logic [7:0] v);
        logic s;
        for (int i = 0; i < 8; i++) begin
            bus_bit(1'b1, s);
            v = {v[6:0], s};
        end
        bus_bit(~give_ack, s);
    endtask

    function automatic logic [7:0] pat(int k);
        return 8'(k * 3 + 1);
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 sda_oe", 32'(sda_oe), 0);
        chk("R1 irq", 32'(irq), 0);
        h_read(A_RXP, d);   chk("R1 rx ptr", d, 0);
        h_read(A_TXP, d);   chk("R1 tx ptr", d, 0);
        h_read(A_FLAGS, d); chk("R1 flags", d, 0);
        h_read(A_OWN, d);   chk("R1 own addr", d, 32'h42);
    endtask

    task automatic t_write();
        logic ack;
        logic [31:0] d;
        logic [7:0] bytes [5] = '{8'hA1, 8'hB2, 8'hC3, 8'hD4, 8'hE5};
        h_write(A_MASK, 32'h7);
        bus_start();
        wr_byte(8'h84, ack); chk("R2 address ack", 32'(ack), 1);
        for (int i = 0; i < 5; i++) begin
            wr_byte(bytes[i], ack);
            chk("R3 data ack", 32'(ack), 1);
        end
        h_read(A_FLAGS, d); chk("R7 no write-end before stop", d, 0);
        bus_stop();
        clks(4);
        h_read(6'h00, d); chk("R3 rx word0", d, 32'hD4C3B2A1);
        h_read(6'h01, d); chk("R3 rx word1", d, 32'h000000E5);
        h_read(A_RXP, d); chk("R3 rx ptr", d, 5);
        h_read(A_FLAGS, d); chk("R7 write-end flag", d, 32'h4);
        chk("R8 irq set", 32'(irq), 1);
        h_write(A_FLAGS, 32'h4);
        h_read(A_FLAGS, d); chk("R8 w1c", d, 0);
        chk("R8 irq cleared", 32'(irq), 0);
    endtask

    task automatic t_mismatch();
        logic ack;
        logic [31:0] d;
        bus_start();
        wr_byte(8'h86, ack); chk("R2 mismatch nack", 32'(ack), 0);
        wr_byte(8'h77, ack); chk("R2 ignored byte nack", 32'(ack), 0);
        bus_stop();
        clks(4);
        h_read(A_RXP, d);   chk("R2 rx ptr unchanged", d, 5);
        h_read(6'h01, d);   chk("R2 rx word1 unchanged", d, 32'h000000E5);
        h_read(A_FLAGS, d); chk("R2 no flag", d, 0);
    endtask

    task automatic t_read();
        logic ack;
        logic [7:0] v;
        logic [31:0] d;
        h_write(6'h10, 32'h44332211);
        h_write(6'h11, 32'h88776655);
        bus_start();
        wr_byte(8'h85, ack); chk("R2 read address ack", 32'(ack), 1);
        h_read(A_FLAGS, d);  chk("R6 read-begun flag", d, 32'h1);
        rd_byte(1'b1, v); chk("R4 byte0", 32'(v), 32'h11);
        rd_byte(1'b1, v); chk("R4 byte1", 32'(v), 32'h22);
        rd_byte(1'b0, v); chk("R4 byte2", 32'(v), 32'h33);
        clks(2);
        chk("R4 released after nack", 32'(sda_oe), 0);
        h_read(A_TXP, d); chk("R4 tx ptr", d, 24);
        bus_stop();
        clks(4);
        h_read(A_FLAGS, d); chk("R7 read-end flag", d, 32'h3);
        h_write(A_FLAGS, 32'h3);
    endtask

    task automatic t_host_map();
        logic [31:0] d;
        h_write(6'h00, 32'hFFFFFFFF);
        h_read(6'h00, d); chk("R5 rx file read-only", d, 32'hD4C3B2A1);
        h_read(6'h11, d); chk("R5 tx readback", d, 32'h88776655);
    endtask

    task automatic t_restart();
        logic ack;
        logic [7:0] v;
        logic [31:0] d;
        bus_start();
        wr_byte(8'h84, ack);
        wr_byte(8'h5A, ack); chk("R3 restart write ack", 32'(ack), 1);
        bus_start();
        clks(4);
        h_read(A_FLAGS, d); chk("R7 write-end at repeated start", d, 32'h4);
        wr_byte(8'h85, ack);
        rd_byte(1'b0, v); chk("R4 byte at ptr 24", 32'(v), 32'h44);
        bus_stop();
        clks(4);
        h_read(A_FLAGS, d); chk("R7 all flags", d, 32'h7);
        h_read(A_TXP, d);   chk("R4 tx ptr 32", d, 32);
        h_read(6'h01, d);   chk("R3 rx word1 after restart", d, 32'h00005AE5);
        h_write(A_MASK, 32'h0);
        clks(1); chk("R8 masked irq", 32'(irq), 0);
        h_write(A_MASK, 32'h2);
        clks(1); chk("R8 single enable irq", 32'(irq), 1);
        h_write(A_FLAGS, 32'h7);
        h_write(A_MASK, 32'h7);
    endtask

    task automatic t_rx_wrap();
        logic ack;
        logic [31:0] d;
        bus_start();
        wr_byte(8'h84, ack);
        for (int i = 0; i < 58; i++) wr_byte(8'(8'h80 + i), ack);
        wr_byte(8'h3C, ack);
        bus_stop();
        clks(4);
        h_read(A_RXP, d);  chk("R3 rx ptr wrapped", d, 1);
        h_read(6'h0F, d);  chk("R3 rx word15", d, 32'hB9B8B7B6);
        h_read(6'h00, d);  chk("R3 rx word0 overwritten", d, 32'hD4C3B23C);
        h_write(A_FLAGS, 32'h7);
    endtask

    task automatic t_tx_wrap();
        logic ack;
        logic [7:0] v;
        logic [31:0] d;
        int bad = 0;
        for (int w = 0; w < 16; w++)
            h_write(6'(16 + w), {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)});
        bus_start();
        wr_byte(8'h85, ack);
        for (int i = 0; i < 61; i++) begin
            rd_byte(i != 60, v);
            if (v !== pat((4 + i) % 64)) bad++;
        end
        bus_stop();
        clks(4);
        chk("R4 wrapped read mismatches", 32'(bad), 0);
        h_read(A_TXP, d); chk("R4 tx ptr wrapped", d, 8);
    endtask

    initial begin
        clks(3);
        rst_n = 1'b1;
        clks(3);
        t_reset();
        t_write();
        t_mismatch();
        t_read();
        t_host_map();
        t_restart();
        t_rx_wrap();
        t_tx_wrap();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end
endmodule